// File: doc/BRIEF.md
# USB Host Interrupt Enable and Threshold Gating

This block produces the single interrupt request line of a USB 2.0 host controller. Six event sources feed it: transfer completion, transfer error, port change, frame list rollover, host system error and async advance. Each source has a one-cycle hardware event pulse that latches a status bit. A software-visible enable bit decides whether that status bit may reach the interrupt line. Software reaches the enable register and the status bits through a minimal register bus: one select bit, a write strobe, write data and combinational read data. Status bits are acknowledged by writing 1 to them.

Port change, frame list rollover and host system error are urgent. Their request is seen on the interrupt line one clock after status and enable are both set. Transfer completion, transfer error and async advance are batched. They are held back until a boundary strobe from a programmable timer that counts microframe ticks. The strobe fires once every 1, 2, 4, 8, 16, 32 or 64 ticks. This limits the interrupt rate for bulk traffic while error and port events still get prompt service.

Top module: `usb_irq_gate`

## Requirements
- R1: After synchronous reset the enable register reads 0, every status bit reads 0, `irq` is 0 and the microframe counter is at zero.
- R2: With `bus_sel`=0, writes load enable bits [5:0] and reads return them. Bit 0 is transfer completion, 1 transfer error, 2 port change, 3 frame list rollover, 4 host system error and 5 async advance. Read data bits [31:6] are always 0, and write data in those bits is dropped.
- R3: A pulse on `evt_set[i]` sets status bit i. With `bus_sel`=1, writing 1 to bit i clears it, and writing 0 leaves it as it was. If a set pulse and a clear arrive in the same cycle, the bit stays set. Read data carries the status in bits [5:0].
- R4: For sources 2, 3 and 4, if status and enable are both 1 after clock edge k, `irq` is 1 after edge k+1.
- R5: For sources 0, 1 and 5, `irq` never rises before a boundary strobe, however long status and enable have both been 1.
- R6: The boundary strobe fires on the clock edge after the microframe tick that brings the tick count to 2^`thr_sel`. A `thr_sel` of 6 or more means 64 ticks. The count then restarts from zero. If `thr_sel` is lowered below the current count, the next tick wraps.
- R7: A batched source whose status and enable are both 1 when the strobe is high becomes pending. `irq` is 1 after the following edge and stays 1 while that source keeps status and enable set.
- R8: Clearing the status bit or the enable bit of a source removes its contribution. With no other source active, `irq` is 0 one edge after the clear has taken effect.
- R9: `irq` is a register. It equals the OR of the urgent source terms and the pending batched flags, taken at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select: 0 enable, 1 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| evt_set | input | 6 | One-cycle hardware event pulses, one per source |
| uframe_tick | input | 1 | One-cycle microframe tick |
| thr_sel | input | 3 | Threshold exponent: 2^thr_sel ticks, at most 64 |
| irq | output | 1 | Level interrupt request |

## Verification
A stale pending flag keeps `irq` high one edge after software has cleared the status or enable bit. A pending flag set too early raises `irq` before the 2^`thr_sel`-th tick. A counter off by one moves the rising edge of `irq` by a full tick interval. Status or enable corruption appears at once on `bus_rdata`. Any of these faults shows at the ports within one or two cycles of the event that should have been visible, or in the cycle of the boundary that comes too early or too late.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int NUM_SRC     = 6;
    localparam int DATA_W      = 32;
    localparam int THR_SEL_W   = 3;
    localparam int MAX_THR_LOG = 6;
    localparam int CNT_W       = MAX_THR_LOG + 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef enum int {
        SRC_XFER   = 0,
        SRC_XERR   = 1,
        SRC_PORT   = 2,
        SRC_ROLL   = 3,
        SRC_SYSERR = 4,
        SRC_ASYNC  = 5
    } src_idx_e;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        src_vec_t wdata;
    } bus_req_t;

    localparam src_vec_t DEFER_MASK =
        src_vec_t'((1 << SRC_XFER) | (1 << SRC_XERR) | (1 << SRC_ASYNC));
    localparam src_vec_t IMM_MASK = ~DEFER_MASK;

    function automatic cnt_t thr_limit(input logic [THR_SEL_W-1:0] sel);
        cnt_t one;
        one = cnt_t'(1);
        if (int'(sel) > MAX_THR_LOG)
            return one << MAX_THR_LOG;
        return one << sel;
    endfunction

endpackage

// File: rtl/usbirq_enable_reg.sv
module usbirq_enable_reg
    import usbirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output src_vec_t en_o
);
    src_vec_t en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (req.wr && req.sel == REG_ENABLE)
            en_q <= req.wdata;
    end

    assign en_o = en_q;

    assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.sel == REG_ENABLE) |=> (en_o == $past(req.wdata)));

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.sel == REG_ENABLE) |=> $stable(en_o));
endmodule

// File: rtl/usbirq_status_reg.sv
module usbirq_status_reg
    import usbirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  src_vec_t evt_set,
    output src_vec_t stat_o
);
    src_vec_t stat_q;
    src_vec_t clr_mask;

    always_comb begin
        clr_mask = '0;
        if (req.wr && req.sel == REG_STATUS)
            clr_mask = req.wdata;
    end

    // a set pulse dominates a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~clr_mask) | evt_set;
    end

    assign stat_o = stat_q;

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_set != '0) |=> ((stat_o & $past(evt_set)) == $past(evt_set)));

    assert_change_cause_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((stat_o ^ $past(stat_o)) & ~$past(evt_set) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/usbirq_thr_timer.sv
module usbirq_thr_timer
    import usbirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [THR_SEL_W-1:0] thr_sel,
    output logic                 bnd_o
);
    cnt_t cnt_q;
    cnt_t cnt_inc;
    cnt_t limit;
    logic bnd_q;

    assign limit   = thr_limit(thr_sel);
    assign cnt_inc = cnt_q + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bnd_q <= 1'b0;
        end else begin
            bnd_q <= 1'b0;
            if (tick) begin
                if (cnt_inc >= limit) begin
                    cnt_q <= '0;
                    bnd_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc;
                end
            end
        end
    end

    assign bnd_o = bnd_q;

    assert_bnd_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        bnd_o |-> $past(tick));

    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q < cnt_t'(1 << MAX_THR_LOG));
endmodule

// File: rtl/usbirq_combine.sv
module usbirq_combine
    import usbirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t stat,
    input  src_vec_t en,
    input  logic     bnd,
    output logic     irq_o
);
    src_vec_t active;
    src_vec_t pend_q;
    src_vec_t pend_d;
    logic     irq_d;
    logic     irq_q;

    assign active = stat & en;
    assign pend_d = active & DEFER_MASK & (pend_q | {NUM_SRC{bnd}});
    assign irq_d  = (|(active & IMM_MASK)) | (|pend_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            irq_q  <= irq_d;
        end
    end

    assign irq_o = irq_q;

    assert_pend_needs_bnd_R5: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q)) != '0) |-> $past(bnd));

    assert_imm_raises_R4: assert property (@(posedge clk) disable iff (rst)
        (|(active & IMM_MASK)) |=> irq_o);

    assert_drop_on_clear_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|active));

    assert_pend_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |-> irq_o);
endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate
    import usbirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   evt_set,
    input  logic                 uframe_tick,
    input  logic [THR_SEL_W-1:0] thr_sel,
    output logic                 irq
);
    bus_req_t req;
    src_vec_t en;
    src_vec_t stat;
    logic     bnd;
    logic     unused_wdata_hi;

    assign req.wr    = bus_wr;
    assign req.sel   = reg_sel_e'(bus_sel);
    assign req.wdata = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    usbirq_enable_reg u_en (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .en_o (en)
    );

    usbirq_status_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .evt_set (evt_set),
        .stat_o  (stat)
    );

    usbirq_thr_timer u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick    (uframe_tick),
        .thr_sel (thr_sel),
        .bnd_o   (bnd)
    );

    usbirq_combine u_cmb (
        .clk   (clk),
        .rst   (rst),
        .stat  (stat),
        .en    (en),
        .bnd   (bnd),
        .irq_o (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.sel == REG_STATUS)
            bus_rdata[NUM_SRC-1:0] = stat;
        else
            bus_rdata[NUM_SRC-1:0] = en;
    end

    assert_irq_clear_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !irq);
endmodule

// File: tb/usb_irq_gate_tb_top.sv
module usb_irq_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_set;
    logic        uframe_tick;
    logic [2:0]  thr_sel;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    usb_irq_gate dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .evt_set     (evt_set),
        .uframe_tick (uframe_tick),
        .thr_sel     (thr_sel),
        .irq         (irq)
    );

    // reference model written from the requirements
    localparam logic [5:0] BATCH  = 6'b100011;
    localparam logic [5:0] URGENT = 6'b011100;
    logic [5:0] m_en, m_st, m_pend, m_act, m_pn;
    int         m_cnt, m_lim;
    logic       m_bnd, m_irq;

    always_comb begin
        m_act = m_st & m_en;
        m_pn  = m_act & BATCH & (m_pend | {6{m_bnd}});
        m_lim = 1 << ((thr_sel > 3'd6) ? 6 : int'(thr_sel));
    end

    always @(posedge clk) begin
        if (rst) begin
            m_en <= '0; m_st <= '0; m_pend <= '0;
            m_cnt <= 0; m_bnd <= 1'b0; m_irq <= 1'b0;
        end else begin
            if (bus_wr && !bus_sel) m_en <= bus_wdata[5:0];
            m_st <= (m_st & ~((bus_wr && bus_sel) ? bus_wdata[5:0] : 6'h0)) | evt_set;
            m_bnd <= 1'b0;
            if (uframe_tick) begin
                if (m_cnt + 1 >= m_lim) begin
                    m_cnt <= 0;
                    m_bnd <= 1'b1;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
            m_pend <= m_pn;
            m_irq  <= (|(m_act & URGENT)) | (|m_pn);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        #2;
        if (cmp_on && !rst) begin
            chk(irq === m_irq, "R9 irq vs model", {31'b0, irq}, {31'b0, m_irq});
            chk(bus_rdata === {26'b0, (bus_sel ? m_st : m_en)},
                bus_sel ? "R3 status read" : "R2 enable read",
                bus_rdata, {26'b0, (bus_sel ? m_st : m_en)});
        end
    end

    task automatic cyc(input logic wr, input logic sel, input logic [31:0] wd,
                       input logic [5:0] ev, input logic tk);
        @(negedge clk);
        bus_wr = wr; bus_sel = sel; bus_wdata = wd; evt_set = ev; uframe_tick = tk;
    endtask

    task automatic idle();
        cyc(1'b0, bus_sel, 32'h0, 6'h0, 1'b0);
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        bus_sel = sel;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_wr = 0; bus_sel = 0; bus_wdata = 0; evt_set = 0; uframe_tick = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; thr_sel = 3'd0;
        bus_wr = 0; bus_sel = 0; bus_wdata = 0; evt_set = 0; uframe_tick = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;

        // R1 reset state
        idle(); #2;
        chk(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(1'b0, v); chk(v == 32'h0, "R1 enable after reset", v, 32'h0);
        rd(1'b1, v); chk(v == 32'h0, "R1 status after reset", v, 32'h0);

        // R2 enable write with reserved bits set
        cyc(1'b1, 1'b0, 32'hFFFF_FFC4, 6'h0, 1'b0);
        idle(); rd(1'b0, v);
        chk(v == 32'h0000_0004, "R2 reserved bits dropped", v, 32'h4);

        // R4 urgent port change: not yet after first edge, set after second
        cyc(1'b0, 1'b0, 32'h0, 6'h04, 1'b0);
        idle(); #2;
        chk(irq == 1'b0, "R4 irq one edge after pulse", {31'b0, irq}, 32'h0);
        idle(); #2;
        chk(irq == 1'b1, "R4 irq after status+enable", {31'b0, irq}, 32'h1);

        // R3 write zero keeps status
        cyc(1'b1, 1'b1, 32'h0, 6'h0, 1'b0);
        idle(); rd(1'b1, v);
        chk(v == 32'h4, "R3 write 0 no effect", v, 32'h4);
        // R3 set wins over clear
        cyc(1'b1, 1'b1, 32'h4, 6'h04, 1'b0);
        idle(); rd(1'b1, v);
        chk(v == 32'h4, "R3 set beats clear", v, 32'h4);
        // R8 clear drops irq
        cyc(1'b1, 1'b1, 32'h4, 6'h0, 1'b0);
        idle(); rd(1'b1, v);
        chk(v == 32'h0, "R3 W1C clears", v, 32'h0);
        idle(); #2;
        chk(irq == 1'b0, "R8 irq drops after clear", {31'b0, irq}, 32'h0);

        // R5 / R7 batched transfer completion with 8-tick threshold
        do_reset();
        thr_sel = 3'd3;
        cyc(1'b1, 1'b0, 32'h1, 6'h0, 1'b0);
        cyc(1'b0, 1'b0, 32'h0, 6'h01, 1'b0);
        repeat (20) idle();
        #2;
        chk(irq == 1'b0, "R5 no irq without boundary", {31'b0, irq}, 32'h0);
        for (int t = 0; t < 7; t++) begin
            cyc(1'b0, 1'b0, 32'h0, 6'h0, 1'b1);
            idle(); idle(); #2;
            chk(irq == 1'b0, "R5 no irq before 8th tick", {31'b0, irq}, 32'h0);
        end
        cyc(1'b0, 1'b0, 32'h0, 6'h0, 1'b1);
        idle(); #2;
        chk(irq == 1'b0, "R7 irq not yet at strobe", {31'b0, irq}, 32'h0);
        idle(); #2;
        chk(irq == 1'b1, "R7 irq after boundary", {31'b0, irq}, 32'h1);
        repeat (5) idle();
        #2;
        chk(irq == 1'b1, "R7 pending holds", {31'b0, irq}, 32'h1);
        // R8 disabling drops it
        cyc(1'b1, 1'b0, 32'h0, 6'h0, 1'b0);
        idle(); idle(); #2;
        chk(irq == 1'b0, "R8 irq drops after disable", {31'b0, irq}, 32'h0);

        // R6 sweep every threshold code with async advance
        for (int s = 0; s < 8; s++) begin
            int lim;
            lim = 1 << ((s > 6) ? 6 : s);
            do_reset();
            thr_sel = 3'(s);
            cyc(1'b1, 1'b0, 32'h20, 6'h0, 1'b0);
            cyc(1'b0, 1'b0, 32'h0, 6'h20, 1'b0);
            for (int t = 0; t < lim - 1; t++) begin
                cyc(1'b0, 1'b0, 32'h0, 6'h0, 1'b1);
                idle();
            end
            idle(); idle(); #2;
            chk(irq == 1'b0, "R6 no strobe before limit", {31'b0, irq}, 32'h0);
            cyc(1'b0, 1'b0, 32'h0, 6'h0, 1'b1);
            idle(); idle(); #2;
            chk(irq == 1'b1, "R6 strobe at limit", {31'b0, irq}, 32'h1);
        end

        // R2 / R3 sweeps over every 6-bit pattern
        do_reset();
        for (int p = 0; p < 64; p++) begin
            cyc(1'b1, 1'b0, {~26'(p), 6'(p)}, 6'h0, 1'b0);
            idle(); rd(1'b0, v);
            chk(v == 32'(p), "R2 enable pattern", v, 32'(p));
            cyc(1'b0, 1'b1, 32'h0, 6'h3F, 1'b0);
            cyc(1'b1, 1'b1, 32'(p), 6'h0, 1'b0);
            idle(); rd(1'b1, v);
            chk(v == 32'(6'h3F & ~6'(p)), "R3 W1C pattern", v, 32'(6'h3F & ~6'(p)));
            cyc(1'b1, 1'b1, 32'h3F, 6'h0, 1'b0);
        end

        // R9 long random run checked cycle by cycle against the model
        do_reset();
        for (int c = 0; c < 30000; c++) begin
            logic [5:0] ev;
            ev = ($urandom % 8 == 0) ? 6'(1 << ($urandom % 6)) : 6'h0;
            if ($urandom % 500 == 0) thr_sel = 3'($urandom);
            cyc(($urandom % 10) == 0, 1'($urandom), $urandom, ev, ($urandom % 3) == 0);
        end
        idle(); idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule